// File: doc/BRIEF.md
# Instruction Prefix and Escape Scanner

This block sits at the front of an instruction decode path. It takes instruction bytes one at a time over a valid/ready handshake and always starts at a known instruction boundary. It walks over the legacy prefixes and the 64-bit register-extension byte, follows the escape bytes and the vector-extension prefix, and stops at the opcode byte. For each instruction it then emits one record. The record holds the collected prefix flags, the effective mandatory prefix, the opcode map, a vector-prefix flag, the opcode byte and an error flag.

The decode rules change with the operating mode, given on `mode_i`: 0 is real 16-bit, 1 is protected 16/32-bit, 2 is 64-bit, and 3 behaves like 1. `mode_i` must stay constant while an instruction is being scanned. The block does not measure ModRM, SIB, displacement or immediate fields. The byte that follows a reported opcode starts the next scan, so an upstream stage must route those bytes elsewhere.

Top module: `insn_prefix_scanner`

## Requirements
- R1: Each legacy prefix byte (F0, F2, F3, 26, 2E, 36, 3E, 64, 65, 66, 67) is accepted and recorded as a flag, and scanning continues. The first byte that is neither a prefix nor an escape is reported as the opcode with map code 0 (one-byte map). `out_lock` reflects F0, `out_opsz` reflects 66 and `out_adsz` reflects 67.
- R2: `out_rep` holds whichever of F2 (code 3) and F3 (code 2) came last, or 0 if neither appeared. Without a vector prefix, `out_mand` is `out_rep` when that is nonzero, otherwise 1 if 66 was seen, otherwise 0. `out_opsz` stays set in both cases.
- R3: `out_seg` reports the last segment override: 26→1, 2E→2, 36→3, 3E→4, 64→5, 65→6, none→0.
- R4: After a 0F byte, the next byte is never treated as a prefix. If that byte is 38 the map is 2, if it is 3A the map is 3, and in both cases the byte after it is the opcode. Any other value is itself the opcode, with map 1.
- R5: In 64-bit mode, bytes 40–4F set `out_rex_v` and put their low nibble on `out_rex`. In the other modes these bytes are one-byte opcodes.
- R6: A register-extension byte that is followed by a legacy prefix is discarded.
- R7: In 64-bit mode, C5 starts a vector prefix with one payload byte. That prefix implies map 1, and the payload's bits [1:0] give `out_mand`. C4 starts a vector prefix with two payload bytes. Bits [4:0] of the first payload select the map (1, 2 or 3; any other value sets `out_err`), and bits [1:0] of the second payload give `out_mand`. The byte after the payload is the opcode, and `out_vex` is 1.
- R8: In protected mode, C4 or C5 starts a vector prefix only when the next byte has bits [7:6] equal to 11. Otherwise the block does not accept that next byte (`in_ready` is 0), and the C4/C5 byte is reported as the opcode with map 0 and `out_vex` 0.
- R9: In real mode, C4 and C5 are always reported as the opcode with map 0, at once.
- R10: If 15 bytes are accepted without reaching an opcode, the block emits a record with `out_err` 1 and `out_opcode` 00 and then returns to idle. An opcode that arrives as the 15th byte is reported without error.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1. A record stays on the outputs unchanged until `out_ready` is sampled high, and no byte is accepted while a record is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Operating mode (0 real, 1 protected, 2 64-bit) |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted at this edge when valid |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Opcode byte |
| out_map | output | 2 | Opcode map (0 one-byte, 1 0F, 2 0F38, 3 0F3A) |
| out_mand | output | 2 | Mandatory prefix (0 none, 1 66, 2 F3, 3 F2) |
| out_vex | output | 1 | Vector prefix used |
| out_err | output | 1 | Overlong or bad-map error |
| out_lock | output | 1 | F0 seen |
| out_opsz | output | 1 | 66 seen |
| out_adsz | output | 1 | 67 seen |
| out_seg | output | 3 | Last segment override code |
| out_rep | output | 2 | Last of F2/F3 (0, 2 or 3) |
| out_rex_v | output | 1 | Register-extension byte kept |
| out_rex | output | 4 | Register-extension low nibble |

## Verification
The scanner is driven with plain opcodes, chains of mixed prefixes, and repeat prefixes in both orders, so that the last-wins rule can be told apart from first-wins and so that F2/F3 can be seen to take priority over 66. Escape sequences are sent with a following byte whose value would otherwise be a prefix, which tells whether forced opcode handling is in place after 0F. The same C4/C5 and 40–4F byte patterns are repeated in each mode, and in protected mode the C4 test is run with both kinds of following byte, which exposes any mode-blind treatment. Prefix chains of 14 and 15 bytes, a register-extension byte followed by a legacy prefix, and a held record cover the length limit, REX discard and output hold behaviour.

// File: rtl/ips_pkg.sv
package ips_pkg;
  typedef enum logic [1:0] {
    MODE_REAL16 = 2'd0,
    MODE_PROT   = 2'd1,
    MODE_LONG   = 2'd2,
    MODE_RSVD   = 2'd3
  } cpu_mode_e;

  typedef enum logic [1:0] {
    MAP_ONE  = 2'd0,
    MAP_0F   = 2'd1,
    MAP_0F38 = 2'd2,
    MAP_0F3A = 2'd3
  } opmap_e;

  localparam logic [1:0] MP_NONE = 2'd0;
  localparam logic [1:0] MP_66   = 2'd1;
  localparam logic [1:0] MP_F3   = 2'd2;
  localparam logic [1:0] MP_F2   = 2'd3;

  // segment override byte -> code, 0 when not a segment override
  function automatic logic [2:0] seg_of(input logic [7:0] b);
    case (b)
      8'h26:   seg_of = 3'd1;
      8'h2E:   seg_of = 3'd2;
      8'h36:   seg_of = 3'd3;
      8'h3E:   seg_of = 3'd4;
      8'h64:   seg_of = 3'd5;
      8'h65:   seg_of = 3'd6;
      default: seg_of = 3'd0;
    endcase
  endfunction

  // repeat prefix outranks operand-size when choosing the mandatory prefix
  function automatic logic [1:0] eff_mand(input logic [1:0] rep, input logic opsz);
    if (rep != MP_NONE) eff_mand = rep;
    else if (opsz)      eff_mand = MP_66;
    else                eff_mand = MP_NONE;
  endfunction

  // vector map select field -> {bad, map}
  function automatic logic [2:0] vex_map(input logic [4:0] m);
    case (m)
      5'd1:    vex_map = {1'b0, MAP_0F};
      5'd2:    vex_map = {1'b0, MAP_0F38};
      5'd3:    vex_map = {1'b0, MAP_0F3A};
      default: vex_map = {1'b1, MAP_ONE};
    endcase
  endfunction
endpackage

// File: rtl/ips_classify.sv
module ips_classify
  import ips_pkg::*;
(
  input  logic [7:0] b_i,
  input  cpu_mode_e  mode_i,
  output logic       is_legacy,
  output logic       is_lock,
  output logic       is_f2,
  output logic       is_f3,
  output logic       is_opsz,
  output logic       is_adsz,
  output logic [2:0] seg_code,
  output logic       is_rex,
  output logic       is_escape,
  output logic       is_vex_lead
);
  always_comb begin
    is_lock     = (b_i == 8'hF0);
    is_f2       = (b_i == 8'hF2);
    is_f3       = (b_i == 8'hF3);
    is_opsz     = (b_i == 8'h66);
    is_adsz     = (b_i == 8'h67);
    seg_code    = seg_of(b_i);
    is_legacy   = is_lock | is_f2 | is_f3 | is_opsz | is_adsz | (seg_code != 3'd0);
    is_rex      = (mode_i == MODE_LONG) && (b_i[7:4] == 4'h4);
    is_escape   = (b_i == 8'h0F);
    is_vex_lead = (b_i[7:1] == 7'b1100_010);
  end
endmodule

// File: rtl/ips_prefix_acc.sv
module ips_prefix_acc
  import ips_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take_legacy,
  input  logic       take_rex,
  input  logic       is_lock,
  input  logic       is_f2,
  input  logic       is_f3,
  input  logic       is_opsz,
  input  logic       is_adsz,
  input  logic [2:0] seg_code,
  input  logic [3:0] rex_bits,
  output logic       lock,
  output logic       opsz,
  output logic       adsz,
  output logic [2:0] seg,
  output logic [1:0] rep,
  output logic       rex_v,
  output logic [3:0] rex
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0; opsz <= 1'b0; adsz <= 1'b0;
      seg <= 3'd0; rep <= MP_NONE; rex_v <= 1'b0; rex <= 4'd0;
    end else if (clr) begin
      lock <= 1'b0; opsz <= 1'b0; adsz <= 1'b0;
      seg <= 3'd0; rep <= MP_NONE; rex_v <= 1'b0; rex <= 4'd0;
    end else if (take_legacy) begin
      if (is_lock) lock <= 1'b1;
      if (is_opsz) opsz <= 1'b1;
      if (is_adsz) adsz <= 1'b1;
      if (seg_code != 3'd0) seg <= seg_code;
      if (is_f2) rep <= MP_F2;
      else if (is_f3) rep <= MP_F3;
      rex_v <= 1'b0;
    end else if (take_rex) begin
      rex_v <= 1'b1;
      rex   <= rex_bits;
    end
  end

  // R6
  rex_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_legacy |=> !rex_v);

  // R2
  rep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep != MP_66);
endmodule

// File: rtl/insn_prefix_scanner.sv
module insn_prefix_scanner
  import ips_pkg::*;
#(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_opcode,
  output logic [1:0] out_map,
  output logic [1:0] out_mand,
  output logic       out_vex,
  output logic       out_err,
  output logic       out_lock,
  output logic       out_opsz,
  output logic       out_adsz,
  output logic [2:0] out_seg,
  output logic [1:0] out_rep,
  output logic       out_rex_v,
  output logic [3:0] out_rex
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_LEN - 1);

  typedef enum logic [2:0] {
    S_PFX, S_ESC, S_ESC3, S_PEEK, S_VEX1, S_VEX2, S_VOP, S_EMIT
  } st_e;

  st_e             state, state_n;
  cpu_mode_e       mode;
  logic [CNT_W-1:0] cnt;
  logic [7:0]      lead_r, lead_n;
  opmap_e          map_r, map_n, d_map;
  logic [1:0]      mand_r, mand_n;
  logic            bad_r, bad_n, d_vex, d_bad;
  logic            hs, vex_ok;
  logic            ev_done, ev_les, ev_overrun, ev_emit, ev_prefix, ev_rex;
  logic [2:0]      vm;

  logic c_legacy, c_lock, c_f2, c_f3, c_opsz, c_adsz, c_rex, c_esc, c_vlead;
  logic [2:0] c_seg;
  logic a_lock, a_opsz, a_adsz, a_rex_v;
  logic [2:0] a_seg;
  logic [1:0] a_rep;
  logic [3:0] a_rex;

  assign mode = cpu_mode_e'(mode_i);

  ips_classify u_cls (
    .b_i(in_byte), .mode_i(mode),
    .is_legacy(c_legacy), .is_lock(c_lock), .is_f2(c_f2), .is_f3(c_f3),
    .is_opsz(c_opsz), .is_adsz(c_adsz), .seg_code(c_seg),
    .is_rex(c_rex), .is_escape(c_esc), .is_vex_lead(c_vlead)
  );

  ips_prefix_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr(ev_emit),
    .take_legacy(ev_prefix), .take_rex(ev_rex),
    .is_lock(c_lock), .is_f2(c_f2), .is_f3(c_f3), .is_opsz(c_opsz),
    .is_adsz(c_adsz), .seg_code(c_seg), .rex_bits(in_byte[3:0]),
    .lock(a_lock), .opsz(a_opsz), .adsz(a_adsz), .seg(a_seg),
    .rep(a_rep), .rex_v(a_rex_v), .rex(a_rex)
  );

  assign vex_ok    = (in_byte[7:6] == 2'b11);
  assign in_ready  = (state != S_EMIT) && !((state == S_PEEK) && !vex_ok);
  assign hs        = in_valid && in_ready;
  assign out_valid = (state == S_EMIT);
  assign vm        = vex_map(in_byte[4:0]);

  always_comb begin
    state_n   = state;
    lead_n    = lead_r;
    map_n     = map_r;
    mand_n    = mand_r;
    bad_n     = bad_r;
    d_map     = MAP_ONE;
    d_vex     = 1'b0;
    d_bad     = 1'b0;
    ev_done   = 1'b0;
    ev_prefix = 1'b0;
    ev_rex    = 1'b0;
    case (state)
      S_PFX: if (hs) begin
        if (c_legacy)      ev_prefix = 1'b1;
        else if (c_rex)    ev_rex = 1'b1;
        else if (c_esc)    state_n = S_ESC;
        else if (c_vlead && mode != MODE_REAL16) begin
          lead_n  = in_byte;
          state_n = (mode == MODE_LONG) ? S_VEX1 : S_PEEK;
        end else begin
          ev_done = 1'b1;
          d_map   = MAP_ONE;
        end
      end
      S_ESC: if (hs) begin
        if (in_byte == 8'h38) begin
          map_n = MAP_0F38; state_n = S_ESC3;
        end else if (in_byte == 8'h3A) begin
          map_n = MAP_0F3A; state_n = S_ESC3;
        end else begin
          ev_done = 1'b1; d_map = MAP_0F;
        end
      end
      S_ESC3: if (hs) begin
        ev_done = 1'b1; d_map = map_r;
      end
      S_PEEK, S_VEX1: if (hs) begin
        if (lead_r[0]) begin
          mand_n  = in_byte[1:0];
          map_n   = MAP_0F;
          state_n = S_VOP;
        end else begin
          bad_n   = vm[2];
          map_n   = opmap_e'(vm[1:0]);
          state_n = S_VEX2;
        end
      end
      S_VEX2: if (hs) begin
        mand_n  = in_byte[1:0];
        state_n = S_VOP;
      end
      S_VOP: if (hs) begin
        ev_done = 1'b1; d_map = map_r; d_vex = 1'b1; d_bad = bad_r;
      end
      S_EMIT: if (out_ready) state_n = S_PFX;
      default: state_n = S_PFX;
    endcase
    ev_les     = (state == S_PEEK) && in_valid && !vex_ok;
    ev_overrun = hs && !ev_done && (cnt == LAST_IDX);
    ev_emit    = ev_done || ev_les || ev_overrun;
    if (ev_emit) begin
      state_n = S_EMIT;
      map_n   = MAP_ONE;
      mand_n  = MP_NONE;
      bad_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_PFX;
      cnt    <= '0;
      lead_r <= 8'h00;
      map_r  <= MAP_ONE;
      mand_r <= MP_NONE;
      bad_r  <= 1'b0;
    end else begin
      state  <= state_n;
      lead_r <= lead_n;
      map_r  <= map_n;
      mand_r <= mand_n;
      bad_r  <= bad_n;
      if (ev_emit)  cnt <= '0;
      else if (hs)  cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_opcode <= 8'h00; out_map <= MAP_ONE; out_mand <= MP_NONE;
      out_vex <= 1'b0; out_err <= 1'b0; out_lock <= 1'b0;
      out_opsz <= 1'b0; out_adsz <= 1'b0; out_seg <= 3'd0;
      out_rep <= MP_NONE; out_rex_v <= 1'b0; out_rex <= 4'd0;
    end else if (ev_emit) begin
      out_opcode <= ev_overrun ? 8'h00 : (ev_les ? lead_r : in_byte);
      out_map    <= (ev_overrun || ev_les) ? MAP_ONE : d_map;
      out_vex    <= d_vex && !ev_overrun;
      out_err    <= ev_overrun || d_bad;
      out_mand   <= (d_vex && !ev_overrun) ? mand_r : eff_mand(a_rep, a_opsz);
      out_lock   <= a_lock;
      out_opsz   <= a_opsz;
      out_adsz   <= a_adsz;
      out_seg    <= a_seg;
      out_rep    <= a_rep;
      out_rex_v  <= a_rex_v;
      out_rex    <= a_rex;
    end
  end

  // R11
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_map) && $stable(out_mand));

  // R11
  no_take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_IDX);

  // R7
  vex_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_vex && !out_err |-> out_map != MAP_ONE);

  // R5
  rex_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rex |-> mode == MODE_LONG);

  // R2
  mand_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_vex && out_rep != MP_NONE |-> out_mand == out_rep);

  // R8
  les_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_les |-> !in_ready && mode != MODE_LONG && mode != MODE_REAL16);
endmodule

// File: tb/insn_prefix_scanner_tb.sv
`timescale 1ns/1ps
module insn_prefix_scanner_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = 2'd2;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid, out_vex, out_err, out_lock, out_opsz, out_adsz, out_rex_v;
  logic [7:0] out_opcode;
  logic [1:0] out_map, out_mand, out_rep;
  logic [2:0] out_seg;
  logic [3:0] out_rex;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  insn_prefix_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_map(out_map), .out_mand(out_mand), .out_vex(out_vex),
    .out_err(out_err), .out_lock(out_lock), .out_opsz(out_opsz), .out_adsz(out_adsz),
    .out_seg(out_seg), .out_rep(out_rep), .out_rex_v(out_rex_v), .out_rex(out_rex)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rec();
    #1;
    while (!out_valid) begin @(negedge clk); #1; end
  endtask

  task automatic pop_rec();
    out_ready = 1'b1; @(posedge clk); @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic core(input string tag, input logic [7:0] opc, input logic [1:0] map,
                      input logic [1:0] mand, input logic vex, input logic err);
    wait_rec();
    chk({tag, " opcode"}, out_opcode, opc);
    chk({tag, " map"}, out_map, map);
    chk({tag, " mand"}, out_mand, mand);
    chk({tag, " vex"}, out_vex, vex);
    chk({tag, " err"}, out_err, err);
  endtask

  task automatic t_reset();
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset in_ready", in_ready, 1);
  endtask

  task automatic t_plain();
    mode_i = 2'd2; put(8'h90);
    core("R1 plain", 8'h90, 0, 0, 0, 0);
    chk("R1 plain lock", out_lock, 0); chk("R1 plain rexv", out_rex_v, 0);
    pop_rec();
  endtask

  task automatic t_legacy();
    put(8'hF0); put(8'h2E); put(8'h67); put(8'h66); put(8'h01);
    core("R1 legacy", 8'h01, 0, 1, 0, 0);
    chk("R1 lock", out_lock, 1); chk("R1 adsz", out_adsz, 1);
    chk("R1 opsz", out_opsz, 1); chk("R3 seg cs", out_seg, 2);
    pop_rec();
  endtask

  task automatic t_rep_last();
    put(8'hF3); put(8'hF2); put(8'h66); put(8'h0F); put(8'h58);
    core("R2 f3f266", 8'h58, 1, 3, 0, 0);
    chk("R2 rep", out_rep, 3); chk("R2 opsz kept", out_opsz, 1);
    pop_rec();
    put(8'hF2); put(8'hF3); put(8'h0F); put(8'h10);
    core("R2 f2f3", 8'h10, 1, 2, 0, 0);
    chk("R2 rep f3", out_rep, 2);
    pop_rec();
  endtask

  task automatic t_seg_last();
    put(8'h26); put(8'h64); put(8'h8B);
    core("R3 seg", 8'h8B, 0, 0, 0, 0);
    chk("R3 seg fs", out_seg, 5);
    pop_rec();
  endtask

  task automatic t_escape();
    put(8'h0F); put(8'hF2);
    core("R4 forced", 8'hF2, 1, 0, 0, 0); chk("R4 forced rep", out_rep, 0); pop_rec();
    put(8'h0F); put(8'h38); put(8'h00);
    core("R4 0f38", 8'h00, 2, 0, 0, 0); pop_rec();
    put(8'h0F); put(8'h3A); put(8'hF0);
    core("R4 0f3a", 8'hF0, 3, 0, 0, 0); chk("R4 0f3a lock", out_lock, 0); pop_rec();
  endtask

  task automatic t_rex();
    mode_i = 2'd2; put(8'h48); put(8'h0F); put(8'hAF);
    core("R5 rex64", 8'hAF, 1, 0, 0, 0);
    chk("R5 rexv", out_rex_v, 1); chk("R5 rex", out_rex, 8); pop_rec();
    mode_i = 2'd1; put(8'h48);
    core("R5 prot inc", 8'h48, 0, 0, 0, 0); chk("R5 prot rexv", out_rex_v, 0); pop_rec();
    mode_i = 2'd2;
  endtask

  task automatic t_rex_drop();
    put(8'h48); put(8'h66); put(8'h01);
    core("R6 drop", 8'h01, 0, 1, 0, 0); chk("R6 rexv", out_rex_v, 0); pop_rec();
    put(8'h66); put(8'h41); put(8'h01);
    core("R6 keep", 8'h01, 0, 1, 0, 0);
    chk("R6 keep rexv", out_rex_v, 1); chk("R6 keep rex", out_rex, 1); pop_rec();
  endtask

  task automatic t_vex64();
    mode_i = 2'd2;
    put(8'hC5); put(8'hF8); put(8'h58);
    core("R7 c5 pp0", 8'h58, 1, 0, 1, 0); pop_rec();
    put(8'hC5); put(8'hFB); put(8'h10);
    core("R7 c5 pp3", 8'h10, 1, 3, 1, 0); pop_rec();
    put(8'hC4); put(8'hE2); put(8'h79); put(8'h18);
    core("R7 c4 map2", 8'h18, 2, 1, 1, 0); pop_rec();
    put(8'hC4); put(8'hE7); put(8'h78); put(8'h00);
    core("R7 c4 badmap", 8'h00, 0, 0, 1, 1); pop_rec();
  endtask

  task automatic t_prot_vex();
    mode_i = 2'd1;
    put(8'hC5); put(8'hC1); put(8'h58);
    core("R8 prot vex", 8'h58, 1, 1, 1, 0); pop_rec();
    put(8'hC4);
    in_valid = 1'b1; in_byte = 8'h06; #1;
    chk("R8 peek not taken", in_ready, 0);
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    core("R8 les", 8'hC4, 0, 0, 0, 0); pop_rec();
    put(8'h90);
    core("R8 after les", 8'h90, 0, 0, 0, 0); pop_rec();
  endtask

  task automatic t_real();
    mode_i = 2'd0;
    put(8'hC5);
    #1; chk("R9 immediate record", out_valid, 1);
    core("R9 real lds", 8'hC5, 0, 0, 0, 0); pop_rec();
    mode_i = 2'd2;
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 15; i++) put(8'h66);
    core("R10 overrun", 8'h00, 0, 1, 0, 1); pop_rec();
    put(8'h90);
    core("R10 idle after", 8'h90, 0, 0, 0, 0); pop_rec();
    for (int i = 0; i < 14; i++) put(8'h67);
    put(8'h90);
    core("R10 fifteen ok", 8'h90, 0, 0, 0, 0); chk("R10 adsz", out_adsz, 1); pop_rec();
  endtask

  task automatic t_hold();
    put(8'h2E); put(8'hC3);
    wait_rec();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R11 hold valid", out_valid, 1);
      chk("R11 hold opcode", out_opcode, 8'hC3);
      chk("R11 hold no input", in_ready, 0);
    end
    pop_rec();
    #1; chk("R11 released", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain(); t_legacy(); t_rep_last(); t_seg_last(); t_escape();
    t_rex(); t_rex_drop(); t_vex64(); t_prot_vex(); t_real();
    t_overrun(); t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule